// File: doc/BRIEF.md
# Debug Command Byte Sequencer

This block is the hardware front end of an on-chip debug engine. While the CPU is halted in debug mode, a host sends bytes over a byte link, each marked by a one-cycle valid strobe. The block decodes each command byte and collects the follow-on bytes the command needs. It packs those bytes least-significant-first into a 16-bit address holding register and a 16-bit data/count holding register. When collection ends, it posts a 4-bit command code for the service firmware and raises a one-cycle jump request to a fixed ROM service vector.

Single-step tracing and the return to normal execution are handled in hardware. Trace releases the CPU for exactly one cycle and then halts it again. Return hands control back to the CPU until the next break request. Password comparison, the service routines and the physical link are outside this block.

Top module: `dbg_cmd_seq`

## Requirements
- R1: After synchronous active-high reset the block is in background mode: `dbg_active`=0, `cpu_run`=1, and `cmd_code`, `addr_reg`, `data_reg`, `byte_buf`, `rom_jump` and `buf_load` are all zero.
- R2: In background mode, link bytes are ignored. A `brk_req` pulse moves the block into debug mode, and from the next cycle `dbg_active`=1 and `cpu_run`=0.
- R3: Command bytes 0x22, 0x23, 0x24 and 0x25 each take four follow-on bytes. The 1st byte goes to `addr_reg[7:0]`, the 2nd to `addr_reg[15:8]`, the 3rd to `data_reg[7:0]` and the 4th to `data_reg[15:8]`. In the cycle after the fourth byte, `cmd_code` equals the command's low nibble and `rom_jump` is high.
- R4: Command byte 0x29 takes two follow-on bytes, placed in `addr_reg[7:0]` then `addr_reg[15:8]`. `data_reg` is left unchanged. In the cycle after the second byte, `cmd_code`=9 and `rom_jump`=1.
- R5: Command byte 0x21 takes no follow-on bytes. In the cycle after it, `cmd_code`=1 and `rom_jump`=1.
- R6: In the cycle after command byte 0x28, `cmd_code`=8 and `rom_jump`=1. Each of the next 32 accepted bytes appears on `byte_buf` with a one-cycle `buf_load` pulse in the cycle after it is accepted, and none of them alters `addr_reg` or `data_reg`.
- R7: `rom_jump` is high for exactly one cycle per command, and `rom_vec` reads 0x8010 whenever it is high.
- R8: After a jump, once collection is complete, link bytes are ignored until a `svc_done` strobe. The strobe returns the block to waiting for a command.
- R9: Command byte 0x26 gives exactly one cycle with `cpu_run`=1 and `dbg_active`=0, starting the cycle after the byte, and then returns to debug mode with `cpu_run`=0.
- R10: Command byte 0x27 returns to background mode (`dbg_active`=0, `cpu_run`=1). Background mode lasts until the next `brk_req`.
- R11: While waiting for a command, a byte whose upper nibble is not 2, or whose low nibble is 0 or greater than 9, changes no output and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Link byte strobe |
| rx_byte | input | 8 | Link byte |
| brk_req | input | 1 | Break request: enter debug mode |
| svc_done | input | 1 | Firmware acknowledge of the jump request |
| dbg_active | output | 1 | CPU halted in debug mode |
| cpu_run | output | 1 | CPU allowed to execute this cycle |
| cmd_code | output | 4 | Command field for the service firmware |
| addr_reg | output | 16 | Address holding register |
| data_reg | output | 16 | Data / count holding register |
| byte_buf | output | 8 | Byte buffer for password bytes |
| buf_load | output | 1 | Pulse: new byte in `byte_buf` |
| rom_jump | output | 1 | Pulse: jump to the service vector |
| rom_vec | output | 16 | Service vector address |

## Verification
A wrong byte counter or mode state shows up within one accepted byte. The jump arrives one byte early or late, or a byte lands in the wrong lane of `addr_reg`/`data_reg`. A stuck wait state shows as ignored commands after `svc_done`, so it is visible on the next command. Errors in the trace path appear on `cpu_run` in the cycle right after 0x26. The bench compares every output against a behavioural model on every clock, so a divergence is reported in the cycle it first reaches a port.

// File: rtl/dbg_seq_pkg.sv
package dbg_seq_pkg;

    typedef enum logic [2:0] {
        ST_BG,
        ST_IDLE,
        ST_COLLECT,
        ST_PW,
        ST_WAIT,
        ST_STEP
    } seq_st_e;

    typedef enum logic [2:0] {
        K_NONE,
        K_MAP,
        K_COLLECT,
        K_PW,
        K_TRACE,
        K_RET
    } op_kind_e;

    localparam logic [3:0] CMD_PREFIX = 4'h2;

endpackage

// File: rtl/dbg_op_decode.sv
module dbg_op_decode
    import dbg_seq_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int WORD_BYTES = 2,
    parameter int CNT_W      = 6
) (
    input  logic [BYTE_W-1:0] cmd_byte,
    output op_kind_e          kind,
    output logic [CNT_W-1:0]  need_n,
    output logic [3:0]        op_nib
);
    localparam logic [CNT_W-1:0] ONE_WORD = CNT_W'(WORD_BYTES);
    localparam logic [CNT_W-1:0] TWO_WORD = CNT_W'(2 * WORD_BYTES);

    logic [3:0] hi_nib;

    always_comb begin
        hi_nib = cmd_byte[7:4];
        op_nib = cmd_byte[3:0];
        kind   = K_NONE;
        need_n = '0;
        if (hi_nib == CMD_PREFIX) begin
            case (op_nib)
                4'h1: kind = K_MAP;
                4'h2, 4'h3, 4'h4, 4'h5: begin
                    kind   = K_COLLECT;
                    need_n = TWO_WORD;
                end
                4'h6: kind = K_TRACE;
                4'h7: kind = K_RET;
                4'h8: kind = K_PW;
                4'h9: begin
                    kind   = K_COLLECT;
                    need_n = ONE_WORD;
                end
                default: kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/dbg_word_asm.sv
module dbg_word_asm #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16,
    localparam int LANES = WORD_W / BYTE_W,
    localparam int IDX_W = $clog2(2 * LANES)
) (
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [WORD_W-1:0] addr_cur,
    input  logic [WORD_W-1:0] data_cur,
    output logic [WORD_W-1:0] addr_nx,
    output logic [WORD_W-1:0] data_nx
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [IDX_W-1:0] A_SEL = IDX_W'(g);
        localparam logic [IDX_W-1:0] D_SEL = IDX_W'(g + LANES);
        assign addr_nx[g*BYTE_W +: BYTE_W] = (we && idx == A_SEL) ? byte_in
                                           : addr_cur[g*BYTE_W +: BYTE_W];
        assign data_nx[g*BYTE_W +: BYTE_W] = (we && idx == D_SEL) ? byte_in
                                           : data_cur[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
    import dbg_seq_pkg::*;
#(
    parameter int          BYTE_W   = 8,
    parameter int          WORD_W   = 16,
    parameter int          PW_BYTES = 32,
    parameter logic [15:0] SVC_VEC  = 16'h8010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              brk_req,
    input  logic              svc_done,
    output logic              dbg_active,
    output logic              cpu_run,
    output logic [3:0]        cmd_code,
    output logic [WORD_W-1:0] addr_reg,
    output logic [WORD_W-1:0] data_reg,
    output logic [BYTE_W-1:0] byte_buf,
    output logic              buf_load,
    output logic              rom_jump,
    output logic [15:0]       rom_vec
);
    localparam int LANES = WORD_W / BYTE_W;
    localparam int IDX_W = $clog2(2 * LANES);
    localparam int CNT_W = $clog2(PW_BYTES + 1);
    localparam logic [CNT_W-1:0] PW_LAST = CNT_W'(PW_BYTES - 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        seq_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  need;
        logic [3:0]        op;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic [3:0]        cmd;
        logic              jump;
        logic [BYTE_W-1:0] bbuf;
        logic              load;
    } seq_reg_t;

    seq_reg_t q_q, q_d;
    seq_st_e  st_w;

    op_kind_e         dec_kind;
    logic [CNT_W-1:0] dec_need;
    logic [3:0]       dec_op;
    logic [WORD_W-1:0] asm_addr, asm_data;
    logic             asm_we;

    dbg_op_decode #(
        .BYTE_W(BYTE_W), .WORD_BYTES(LANES), .CNT_W(CNT_W)
    ) u_dec (
        .cmd_byte(rx_byte), .kind(dec_kind), .need_n(dec_need), .op_nib(dec_op)
    );

    assign asm_we = rx_valid && (q_q.st == ST_COLLECT);

    dbg_word_asm #(
        .BYTE_W(BYTE_W), .WORD_W(WORD_W)
    ) u_asm (
        .we(asm_we), .idx(q_q.cnt[IDX_W-1:0]), .byte_in(rx_byte),
        .addr_cur(q_q.addr), .data_cur(q_q.data),
        .addr_nx(asm_addr), .data_nx(asm_data)
    );

    always_comb begin
        q_d      = q_q;
        q_d.jump = 1'b0;
        q_d.load = 1'b0;
        case (q_q.st)
            ST_BG: begin
                if (brk_req) q_d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (rx_valid) begin
                    case (dec_kind)
                        K_MAP: begin
                            q_d.cmd  = dec_op;
                            q_d.jump = 1'b1;
                            q_d.st   = ST_WAIT;
                        end
                        K_COLLECT: begin
                            q_d.cnt  = '0;
                            q_d.need = dec_need;
                            q_d.op   = dec_op;
                            q_d.st   = ST_COLLECT;
                        end
                        K_PW: begin
                            q_d.cmd  = dec_op;
                            q_d.jump = 1'b1;
                            q_d.cnt  = '0;
                            q_d.st   = ST_PW;
                        end
                        K_TRACE: q_d.st = ST_STEP;
                        K_RET:   q_d.st = ST_BG;
                        default: ;
                    endcase
                end
            end
            ST_COLLECT: begin
                if (rx_valid) begin
                    q_d.addr = asm_addr;
                    q_d.data = asm_data;
                    q_d.cnt  = q_q.cnt + CNT_ONE;
                    if (q_q.cnt + CNT_ONE == q_q.need) begin
                        q_d.cmd  = q_q.op;
                        q_d.jump = 1'b1;
                        q_d.st   = ST_WAIT;
                    end
                end
            end
            ST_PW: begin
                if (rx_valid) begin
                    q_d.bbuf = rx_byte;
                    q_d.load = 1'b1;
                    q_d.cnt  = q_q.cnt + CNT_ONE;
                    if (q_q.cnt == PW_LAST) q_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (svc_done) q_d.st = ST_IDLE;
            end
            ST_STEP: q_d.st = ST_IDLE;
            default: q_d.st = ST_BG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q <= '{st: ST_BG, default: '0};
        end else begin
            q_q <= q_d;
        end
    end

    assign st_w       = q_q.st;
    assign dbg_active = (q_q.st != ST_BG) && (q_q.st != ST_STEP);
    assign cpu_run    = (q_q.st == ST_BG) || (q_q.st == ST_STEP);
    assign cmd_code   = q_q.cmd;
    assign addr_reg   = q_q.addr;
    assign data_reg   = q_q.data;
    assign byte_buf   = q_q.bbuf;
    assign buf_load   = q_q.load;
    assign rom_jump   = q_q.jump;
    assign rom_vec    = SVC_VEC;
endmodule

// File: rtl/dbg_cmd_seq_chk.sv
module dbg_cmd_seq_chk
    import dbg_seq_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        rx_valid,
    input logic [7:0]  rx_byte,
    input logic        brk_req,
    input logic        svc_done,
    input seq_st_e     st,
    input logic        dbg_active,
    input logic        cpu_run,
    input logic        rom_jump,
    input logic [3:0]  cmd_code,
    input logic [15:0] addr_reg,
    input logic [15:0] data_reg
);
    logic known_cmd;
    assign known_cmd = (rx_byte[7:4] == 4'h2) && (rx_byte[3:0] != 4'h0)
                       && (rx_byte[3:0] <= 4'h9);

    AST_BREAK_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BG && brk_req) |=> (dbg_active && !cpu_run)); // R2

    AST_JUMP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rom_jump |=> !rom_jump); // R7

    AST_WAIT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT && !svc_done) |=> (st == ST_WAIT && $stable(addr_reg)
            && $stable(data_reg) && $stable(cmd_code))); // R8

    AST_TRACE_START: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && rx_valid && rx_byte == 8'h26) |=> (cpu_run && !dbg_active)); // R9

    AST_TRACE_ONE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STEP) |=> (dbg_active && !cpu_run)); // R9

    AST_RETURN_BG: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && rx_valid && rx_byte == 8'h27) |=> (!dbg_active && cpu_run)); // R10

    AST_NOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && rx_valid && !known_cmd) |=> (st == ST_IDLE && !rom_jump
            && $stable(addr_reg) && $stable(data_reg) && $stable(cmd_code))); // R11
endmodule

bind dbg_cmd_seq dbg_cmd_seq_chk u_chk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .brk_req(brk_req), .svc_done(svc_done), .st(st_w),
    .dbg_active(dbg_active), .cpu_run(cpu_run), .rom_jump(rom_jump),
    .cmd_code(cmd_code), .addr_reg(addr_reg), .data_reg(data_reg)
);

// File: tb/dbg_cmd_seq_test.sv
module dbg_cmd_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        brk_req = 1'b0;
    logic        svc_done = 1'b0;
    logic        dbg_active, cpu_run, buf_load, rom_jump;
    logic [3:0]  cmd_code;
    logic [15:0] addr_reg, data_reg, rom_vec;
    logic [7:0]  byte_buf;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    dbg_cmd_seq uut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .brk_req(brk_req), .svc_done(svc_done), .dbg_active(dbg_active),
        .cpu_run(cpu_run), .cmd_code(cmd_code), .addr_reg(addr_reg),
        .data_reg(data_reg), .byte_buf(byte_buf), .buf_load(buf_load),
        .rom_jump(rom_jump), .rom_vec(rom_vec)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural reference: mode 0 background, 1 idle, 2 collecting words,
    // 3 collecting password bytes, 4 waiting for firmware, 5 single step.
    int m_mode, m_need, m_cnt, m_op, m_cmd;
    int m_addr, m_data, m_buf;
    bit m_jump, m_load;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_need = 0; m_cnt = 0; m_op = 0; m_cmd = 0;
            m_addr = 0; m_data = 0; m_buf = 0; m_jump = 0; m_load = 0;
        end else begin
            m_jump = 0;
            m_load = 0;
            if (m_mode == 0) begin
                if (brk_req) m_mode = 1;
            end else if (m_mode == 1) begin
                if (rx_valid && rx_byte[7:4] == 4'h2) begin
                    int lo;
                    lo = int'(rx_byte[3:0]);
                    if (lo == 1) begin m_cmd = 1; m_jump = 1; m_mode = 4; end
                    else if (lo >= 2 && lo <= 5) begin m_op = lo; m_need = 4; m_cnt = 0; m_mode = 2; end
                    else if (lo == 9) begin m_op = 9; m_need = 2; m_cnt = 0; m_mode = 2; end
                    else if (lo == 8) begin m_cmd = 8; m_jump = 1; m_cnt = 0; m_mode = 3; end
                    else if (lo == 6) m_mode = 5;
                    else if (lo == 7) m_mode = 0;
                end
            end else if (m_mode == 2) begin
                if (rx_valid) begin
                    if (m_cnt < 2) m_addr = (m_addr & ~(255 << (8 * m_cnt))) | (int'(rx_byte) << (8 * m_cnt));
                    else m_data = (m_data & ~(255 << (8 * (m_cnt - 2)))) | (int'(rx_byte) << (8 * (m_cnt - 2)));
                    m_cnt++;
                    if (m_cnt == m_need) begin m_cmd = m_op; m_jump = 1; m_mode = 4; end
                end
            end else if (m_mode == 3) begin
                if (rx_valid) begin
                    m_buf = int'(rx_byte); m_load = 1; m_cnt++;
                    if (m_cnt == 32) m_mode = 4;
                end
            end else if (m_mode == 4) begin
                if (svc_done) m_mode = 1;
            end else begin
                m_mode = 1;
            end
        end
    end

    task automatic fail_line(string req, string what, int act, int exp);
        errors++;
        $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit exp_dbg, exp_run;
            exp_dbg = (m_mode >= 1 && m_mode <= 4);
            exp_run = (m_mode == 0 || m_mode == 5);
            checks++;
            if (dbg_active !== exp_dbg) fail_line(cur_req, "dbg_active", int'(dbg_active), int'(exp_dbg));
            else if (cpu_run !== exp_run) fail_line(cur_req, "cpu_run", int'(cpu_run), int'(exp_run));
            else if (cmd_code !== 4'(m_cmd)) fail_line(cur_req, "cmd_code", int'(cmd_code), m_cmd);
            else if (addr_reg !== 16'(m_addr)) fail_line(cur_req, "addr_reg", int'(addr_reg), m_addr);
            else if (data_reg !== 16'(m_data)) fail_line(cur_req, "data_reg", int'(data_reg), m_data);
            else if (rom_jump !== m_jump) fail_line(cur_req, "rom_jump", int'(rom_jump), int'(m_jump));
            else if (buf_load !== m_load) fail_line(cur_req, "buf_load", int'(buf_load), int'(m_load));
            else if (m_load && byte_buf !== 8'(m_buf)) fail_line(cur_req, "byte_buf", int'(byte_buf), m_buf);
            else if (rom_jump && rom_vec !== 16'h8010) fail_line("R7", "rom_vec", int'(rom_vec), 32'h8010);
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) fail_line(req, what, act, exp);
    endtask

    task automatic send(logic [7:0] b);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic idle_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ack();
        svc_done = 1'b1;
        @(negedge clk);
        svc_done = 1'b0;
    endtask

    task automatic brk();
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<%0d", cycles, WATCHDOG);
            summary();
        end
    end

    initial begin
        idle_cycles(3);
        rst = 1'b0;
        cur_req = "R1";
        chk("R1", "dbg_active", int'(dbg_active), 0);
        chk("R1", "cpu_run", int'(cpu_run), 1);
        chk("R1", "addr_reg", int'(addr_reg), 0);
        chk("R1", "cmd_code", int'(cmd_code), 0);

        cur_req = "R2";
        send(8'h21);
        idle_cycles(2);
        chk("R2", "rom_jump in background", int'(rom_jump), 0);
        brk();
        chk("R2", "dbg_active after break", int'(dbg_active), 1);
        chk("R2", "cpu_run after break", int'(cpu_run), 0);

        cur_req = "R3";
        send(8'h25); send(8'h34); idle_cycles(1); send(8'h12);
        send(8'h78); send(8'h56);
        chk("R3", "addr_reg", int'(addr_reg), 32'h1234);
        chk("R3", "data_reg", int'(data_reg), 32'h5678);
        chk("R3", "cmd_code", int'(cmd_code), 5);
        chk("R7", "rom_jump high", int'(rom_jump), 1);
        chk("R7", "rom_vec", int'(rom_vec), 32'h8010);
        idle_cycles(1);
        chk("R7", "rom_jump low", int'(rom_jump), 0);

        cur_req = "R8";
        send(8'h22); send(8'h11);
        chk("R8", "addr_reg while waiting", int'(addr_reg), 32'h1234);
        ack();
        cur_req = "R3";
        send(8'h22); send(8'hEF); send(8'hBE); send(8'h10); send(8'h00);
        chk("R3", "count word", int'(data_reg), 32'h0010);
        ack();
        send(8'h23); send(8'h01); send(8'h02); send(8'h03); send(8'h04);
        ack();
        send(8'h24); send(8'hAA); send(8'h55); send(8'hC3); send(8'h3C);
        chk("R3", "cmd_code write reg", int'(cmd_code), 4);
        ack();

        cur_req = "R4";
        send(8'h29); send(8'hAB); send(8'hCD);
        chk("R4", "addr_reg", int'(addr_reg), 32'hCDAB);
        chk("R4", "data_reg unchanged", int'(data_reg), 32'h3CC3);
        chk("R4", "cmd_code", int'(cmd_code), 9);
        ack();

        cur_req = "R5";
        send(8'h21);
        chk("R5", "cmd_code", int'(cmd_code), 1);
        chk("R5", "rom_jump", int'(rom_jump), 1);
        ack();

        cur_req = "R11";
        send(8'h20); send(8'h2A); send(8'h31); send(8'hFF); send(8'h2F); send(8'h01);
        chk("R11", "cmd_code after no-ops", int'(cmd_code), 1);
        chk("R11", "rom_jump after no-ops", int'(rom_jump), 0);

        cur_req = "R6";
        send(8'h28);
        chk("R6", "cmd_code", int'(cmd_code), 8);
        for (int i = 0; i < 32; i++) begin
            send(8'(i * 7 + 3));
            chk("R6", "byte_buf", int'(byte_buf), (i * 7 + 3) & 255);
            if (i % 5 == 0) idle_cycles(1);
        end
        chk("R6", "addr_reg untouched", int'(addr_reg), 32'hCDAB);
        cur_req = "R8";
        send(8'h21);
        chk("R8", "rom_jump after 32 bytes", int'(rom_jump), 0);
        ack();
        ack();

        cur_req = "R9";
        send(8'h26);
        chk("R9", "cpu_run step", int'(cpu_run), 1);
        chk("R9", "dbg_active step", int'(dbg_active), 0);
        idle_cycles(1);
        chk("R9", "cpu_run halted", int'(cpu_run), 0);
        idle_cycles(2);

        cur_req = "R10";
        send(8'h27);
        idle_cycles(3);
        chk("R10", "cpu_run background", int'(cpu_run), 1);
        send(8'h21);
        chk("R10", "rom_jump in background", int'(rom_jump), 0);
        brk();
        chk("R10", "dbg_active after second break", int'(dbg_active), 1);
        idle_cycles(2);

        done = 1'b1;
        summary();
    end
endmodule